// File: doc/BRIEF.md
# MDIO Management Target

This block is the device-side end of a two-wire serial management link. A fast system clock oversamples the management clock and data line. The block follows each frame bit by bit. It finds the preamble and the start pattern, and it decodes whether the frame reads or writes. It serves only frames whose 5-bit device address equals a strap input. A read frame makes the block take the bidirectional line at the turnaround and shift out a 16-bit register value. A write frame makes the block collect 16 bits and hand them to a local register port.

The register port is plain and has no back-pressure. The block presents the register address, and the read value must come back combinationally in the same system clock. A write is a single-cycle strobe that carries the address and the data. It assumes the register file always accepts, so there is no ready signal. The register space has a hole: addresses 7 to 15 are never forwarded, and a read of one of them returns all ones. The management clock is aperiodic and may stop for any length of time. The system clock must be at least 25 MHz.

Top module: `mdio_target`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive one bits, followed by a 0 then a 1. A shorter run of ones, or a run broken by a zero, makes the block ignore the frame: no write strobe and no drive of the line.
- R2: The two opcode bits that follow the start pattern select read for 1,0 and write for 0,1. The patterns 0,0 and 1,1 make the block ignore the frame.
- R3: Next come a 5-bit device address and a 5-bit register address, each sent most significant bit first. If the device address differs from `phy_addr_i`, the block never drives the line and issues no write.
- R4: During the first turnaround bit of a matched read, `mdio_oe` stays low. After the next MDC rising edge the block drives 0. It then places data bit 15 first, down to bit 0, each just after an MDC rising edge, so that the controller samples each bit on the following rising edge.
- R5: A read of register address 7 to 15 returns 16'hFFFF. A read of any other address returns the value of `reg_rdata_i`, taken while `reg_addr_o` holds that address.
- R6: A matched write must carry turnaround bits 1 then 0. After the 16th data bit the block raises `reg_we_o` for exactly one system clock, with the register address on `reg_addr_o` and the data, MSB first, on `reg_wdata_o`. Wrong turnaround bits cancel the write.
- R7: A write to register address 7 to 15 produces no strobe on `reg_we_o`.
- R8: `mdio_oe` is low outside the turnaround and data phase of a matched read. It is low again after the last data bit, and it is never high in the same cycle as `reg_we_o`.
- R9: The bit position in a frame is held for any length of time while MDC does not toggle. While the line is driven, its value changes only in response to an MDC rising edge.
- R10: After reset, `mdio_oe` and `reg_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 25 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr_i | input | 5 | Strapped device address |
| mdc_i | input | 1 | Management clock, asynchronous |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Data value driven onto the line |
| mdio_oe | output | 1 | Drive enable for the line |
| reg_addr_o | output | 5 | Register address of the current frame |
| reg_rdata_i | input | 16 | Register read value for `reg_addr_o` |
| reg_wdata_o | output | 16 | Write data |
| reg_we_o | output | 1 | Single-cycle write strobe |

## Verification
Every one of the 32 register addresses is read, and every one is written with data computed from the address. The sweep separates the forwarded ranges from the hole and checks the bit order and the turnaround drive. The malformed patterns set apart each early-exit path: a 31-bit preamble, a preamble broken by a zero, the two invalid opcodes, a mismatched device address and wrong turnaround bits. In each case, a following valid frame shows that hunting resumed. Runs at the minimum MDC high time, and with a long MDC stall in the middle of a frame, show that sampling holds at the edge of the timing range and that state survives while MDC is idle.

// File: rtl/mdio_tgt_pkg.sv
package mdio_tgt_pkg;
  typedef enum logic [2:0] {
    S_HUNT,
    S_SOF,
    S_OPC,
    S_DEV,
    S_REG,
    S_TURN,
    S_DATA
  } fsm_t;
endpackage

// File: rtl/mdio_tgt_sync.sv
module mdio_tgt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc_i,
  input  logic mdio_i,
  output logic bit_o,
  output logic rise_o
);
  logic [STAGES-1:0] mdc_ff;
  logic [STAGES-1:0] dat_ff;
  logic              mdc_last;

  // reset high so a clock parked high gives no false edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_ff   <= '1;
      dat_ff   <= '1;
      mdc_last <= 1'b1;
    end else begin
      mdc_ff   <= {mdc_ff[STAGES-2:0], mdc_i};
      dat_ff   <= {dat_ff[STAGES-2:0], mdio_i};
      mdc_last <= mdc_ff[STAGES-1];
    end
  end

  assign rise_o = mdc_ff[STAGES-1] & ~mdc_last;
  assign bit_o  = dat_ff[STAGES-1];
endmodule

// File: rtl/mdio_tgt_frame.sv
module mdio_tgt_frame
  import mdio_tgt_pkg::*;
#(
  parameter int unsigned AW      = 5,
  parameter int unsigned DW      = 16,
  parameter int unsigned PRE_LEN = 32,
  parameter int unsigned HOLE_LO = 7,
  parameter int unsigned HOLE_HI = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_i,
  input  logic          bit_i,
  input  logic [AW-1:0] strap_i,
  input  logic [DW-1:0] rdata_i,
  output logic          mdio_o,
  output logic          mdio_oe,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          we_o
);
  localparam int unsigned CW = $clog2(PRE_LEN + 1);
  localparam int unsigned NW = ((DW > AW) ? $clog2(DW) : $clog2(AW)) + 1;

  fsm_t          st;
  logic [CW-1:0] ones;
  logic [NW-1:0] cnt;
  logic          op_hi;
  logic          is_rd;
  logic [AW-1:0] dev_q;
  logic [AW-1:0] reg_q;
  logic [DW-1:0] sh;

  function automatic logic addr_live(input logic [AW-1:0] a);
    return !((int'(a) >= int'(HOLE_LO)) && (int'(a) <= int'(HOLE_HI)));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_HUNT;
      ones    <= '0;
      cnt     <= '0;
      op_hi   <= 1'b0;
      is_rd   <= 1'b0;
      dev_q   <= '0;
      reg_q   <= '0;
      sh      <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      we_o    <= 1'b0;
    end else begin
      we_o <= 1'b0;
      if (rise_i) begin
        case (st)
          S_HUNT: begin
            if (bit_i) begin
              if (ones != CW'(PRE_LEN)) ones <= ones + 1'b1;
            end else begin
              if (ones == CW'(PRE_LEN)) st <= S_SOF;
              ones <= '0;
            end
          end
          S_SOF: begin
            st  <= bit_i ? S_OPC : S_HUNT;
            cnt <= '0;
          end
          S_OPC: begin
            if (cnt == NW'(1)) begin
              cnt <= '0;
              if (op_hi != bit_i) begin
                is_rd <= op_hi;
                st    <= S_DEV;
              end else begin
                st <= S_HUNT;
              end
            end else begin
              op_hi <= bit_i;
              cnt   <= cnt + 1'b1;
            end
          end
          S_DEV: begin
            dev_q <= {dev_q[AW-2:0], bit_i};
            if (cnt == NW'(AW - 1)) begin
              cnt <= '0;
              st  <= S_REG;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_REG: begin
            reg_q <= {reg_q[AW-2:0], bit_i};
            if (cnt == NW'(AW - 1)) begin
              cnt <= '0;
              st  <= (dev_q == strap_i) ? S_TURN : S_HUNT;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_TURN: begin
            if (cnt == '0) begin
              if (is_rd) begin
                mdio_oe <= 1'b1;
                mdio_o  <= 1'b0;
                sh      <= addr_live(reg_q) ? rdata_i : '1;
                cnt     <= NW'(1);
              end else if (bit_i) begin
                cnt <= NW'(1);
              end else begin
                st <= S_HUNT;
              end
            end else begin
              cnt <= '0;
              if (is_rd) begin
                mdio_o <= sh[DW-1];
                sh     <= {sh[DW-2:0], 1'b0};
                st     <= S_DATA;
              end else begin
                st <= bit_i ? S_HUNT : S_DATA;
              end
            end
          end
          S_DATA: begin
            if (cnt == NW'(DW - 1)) begin
              cnt <= '0;
              st  <= S_HUNT;
            end else begin
              cnt <= cnt + 1'b1;
            end
            if (is_rd) begin
              if (cnt == NW'(DW - 1)) begin
                mdio_oe <= 1'b0;
              end else begin
                mdio_o <= sh[DW-1];
                sh     <= {sh[DW-2:0], 1'b0};
              end
            end else begin
              sh <= {sh[DW-2:0], bit_i};
              if (cnt == NW'(DW - 1)) we_o <= addr_live(reg_q);
            end
          end
          default: st <= S_HUNT;
        endcase
      end
    end
  end

  assign addr_o  = reg_q;
  assign wdata_o = sh;
endmodule

// File: rtl/mdio_target.sv
module mdio_target #(
  parameter int unsigned AW          = 5,
  parameter int unsigned DW          = 16,
  parameter int unsigned PRE_LEN     = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLE_LO     = 7,
  parameter int unsigned HOLE_HI     = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] phy_addr_i,
  input  logic          mdc_i,
  input  logic          mdio_i,
  output logic          mdio_o,
  output logic          mdio_oe,
  output logic [AW-1:0] reg_addr_o,
  input  logic [DW-1:0] reg_rdata_i,
  output logic [DW-1:0] reg_wdata_o,
  output logic          reg_we_o
);
  logic mdc_rise;
  logic mdio_bit;

  mdio_tgt_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .mdc_i  (mdc_i),
    .mdio_i (mdio_i),
    .bit_o  (mdio_bit),
    .rise_o (mdc_rise)
  );

  mdio_tgt_frame #(
    .AW(AW), .DW(DW), .PRE_LEN(PRE_LEN), .HOLE_LO(HOLE_LO), .HOLE_HI(HOLE_HI)
  ) frame_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_i  (mdc_rise),
    .bit_i   (mdio_bit),
    .strap_i (phy_addr_i),
    .rdata_i (reg_rdata_i),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .addr_o  (reg_addr_o),
    .wdata_o (reg_wdata_o),
    .we_o    (reg_we_o)
  );
endmodule

// File: rtl/mdio_target_chk.sv
module mdio_target_chk #(
  parameter int unsigned AW      = 5,
  parameter int unsigned HOLE_LO = 7,
  parameter int unsigned HOLE_HI = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mdc_rise,
  input logic          mdio_oe,
  input logic          mdio_o,
  input logic          reg_we_o,
  input logic [AW-1:0] reg_addr_o
);
  assert_we_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> !reg_we_o);

  assert_hole_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> ((int'(reg_addr_o) < int'(HOLE_LO)) || (int'(reg_addr_o) > int'(HOLE_HI))));

  assert_no_collide_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we_o && mdio_oe));

  assert_oe_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> $past(mdc_rise));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && $past(mdio_oe) && !$past(mdc_rise)) |-> $stable(mdio_o));

  assert_addr_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && $past(mdio_oe)) |-> $stable(reg_addr_o));
endmodule

bind mdio_target mdio_target_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .mdc_rise   (mdc_rise),
  .mdio_oe    (mdio_oe),
  .mdio_o     (mdio_o),
  .reg_we_o   (reg_we_o),
  .reg_addr_o (reg_addr_o)
);

// File: tb/mdio_target_tb_top.sv
`timescale 1ns/1ps
module mdio_target_tb_top;
  localparam logic [4:0] STRAP = 5'h13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mdc = 1'b0;
  logic        tb_drv = 1'b1;
  logic        mdio_line;
  logic        mdio_o, mdio_oe, reg_we_o;
  logic [4:0]  reg_addr_o;
  logic [15:0] reg_rdata_i, reg_wdata_o;

  int checks = 0;
  int errors = 0;
  int we_cnt = 0;
  logic [4:0]  w_addr;
  logic [15:0] w_data;
  logic oe_seen = 1'b0;
  bit   done = 1'b0;
  int   lo_ns = 240;
  int   hi_ns = 160;
  int   stall_ns = 0;

  always #10 clk = ~clk;

  function automatic logic [15:0] model(input logic [4:0] a);
    return {a, ~a, a, 1'b1};
  endfunction
  function automatic bit in_hole(input logic [4:0] a);
    return (a >= 5'd7) && (a <= 5'd15);
  endfunction

  assign reg_rdata_i = model(reg_addr_o);
  assign mdio_line   = mdio_oe ? mdio_o : tb_drv;

  mdio_target dut_i (
    .clk(clk), .rst_n(rst_n), .phy_addr_i(STRAP), .mdc_i(mdc), .mdio_i(mdio_line),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .reg_addr_o(reg_addr_o),
    .reg_rdata_i(reg_rdata_i), .reg_wdata_o(reg_wdata_o), .reg_we_o(reg_we_o)
  );

  always @(negedge clk) begin
    if (reg_we_o) begin
      we_cnt = we_cnt + 1;
      w_addr = reg_addr_o;
      w_data = reg_wdata_o;
    end
    if (mdio_oe) oe_seen = 1'b1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bit_cyc(input logic b, output logic s);
    tb_drv = b;
    #(lo_ns);
    mdc = 1'b1;
    s = mdio_line;
    #(hi_ns);
    mdc = 1'b0;
  endtask

  task automatic frame(input int pre, input logic [1:0] op, input logic [4:0] pa,
                       input logic [4:0] ra, input logic [1:0] ta, input logic [15:0] wd,
                       input bit rd, output logic [15:0] rdv, output logic ta1_oe,
                       output logic ta2_v);
    logic s;
    for (int i = 0; i < pre; i++) bit_cyc(1'b1, s);
    bit_cyc(1'b0, s);
    bit_cyc(1'b1, s);
    for (int i = 1; i >= 0; i--) bit_cyc(op[i], s);
    for (int i = 4; i >= 0; i--) bit_cyc(pa[i], s);
    for (int i = 4; i >= 0; i--) bit_cyc(ra[i], s);
    if (stall_ns > 0) #(stall_ns);
    if (rd) begin
      tb_drv = 1'b1;
      #(lo_ns); mdc = 1'b1; ta1_oe = mdio_oe; s = mdio_line; #(hi_ns); mdc = 1'b0;
      bit_cyc(1'b1, ta2_v);
      for (int i = 15; i >= 0; i--) begin
        bit_cyc(1'b1, s);
        rdv[i] = s;
      end
    end else begin
      ta1_oe = 1'b0;
      ta2_v  = 1'b0;
      rdv    = '0;
      bit_cyc(ta[1], s);
      bit_cyc(ta[0], s);
      for (int i = 15; i >= 0; i--) bit_cyc(wd[i], s);
    end
    tb_drv = 1'b1;
    #200;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rdv, wd;
    logic t1, t2;
    int base;
    #53;
    chk("R10 oe after reset", 32'(mdio_oe), 32'd0);
    chk("R10 we after reset", 32'(reg_we_o), 32'd0);
    rst_n = 1'b1;
    #100;

    // read sweep at minimum high time
    for (int a = 0; a < 32; a++) begin
      frame(32, 2'b10, STRAP, 5'(a), 2'b00, 16'h0, 1'b1, rdv, t1, t2);
      chk(in_hole(5'(a)) ? "R5 hole read" : "R4 read data", 32'(rdv),
          32'(in_hole(5'(a)) ? 16'hFFFF : model(5'(a))));
      chk("R4 turnaround1 released", 32'(t1), 32'd0);
      chk("R4 turnaround2 driven low", 32'(t2), 32'd0);
      chk("R8 oe low after read", 32'(mdio_oe), 32'd0);
    end

    // write sweep, symmetric timing
    lo_ns = 200; hi_ns = 200;
    for (int a = 0; a < 32; a++) begin
      base = we_cnt;
      wd = 16'(a * 16'h0911) ^ 16'h5A3C;
      frame(32, 2'b01, STRAP, 5'(a), 2'b10, wd, 1'b0, rdv, t1, t2);
      if (in_hole(5'(a))) begin
        chk("R7 hole write ignored", 32'(we_cnt - base), 32'd0);
      end else begin
        chk("R6 one strobe", 32'(we_cnt - base), 32'd1);
        chk("R6 write addr", 32'(w_addr), 32'(a));
        chk("R6 write data", 32'(w_data), 32'(wd));
      end
    end

    // mismatched device address
    oe_seen = 1'b0;
    frame(32, 2'b10, STRAP ^ 5'h01, 5'd2, 2'b00, 16'h0, 1'b1, rdv, t1, t2);
    chk("R3 mismatch read passive", 32'(oe_seen), 32'd0);
    base = we_cnt;
    frame(32, 2'b01, STRAP ^ 5'h10, 5'd3, 2'b10, 16'h0, 1'b0, rdv, t1, t2);
    chk("R3 mismatch write ignored", 32'(we_cnt - base), 32'd0);

    // short preamble and broken preamble
    base = we_cnt;
    frame(31, 2'b01, STRAP, 5'd4, 2'b10, 16'h0, 1'b0, rdv, t1, t2);
    chk("R1 short preamble ignored", 32'(we_cnt - base), 32'd0);
    for (int i = 0; i < 16; i++) bit_cyc(1'b1, t1);
    bit_cyc(1'b0, t1);
    frame(16, 2'b01, STRAP, 5'd4, 2'b10, 16'h0, 1'b0, rdv, t1, t2);
    chk("R1 broken preamble ignored", 32'(we_cnt - base), 32'd0);
    frame(40, 2'b01, STRAP, 5'd5, 2'b10, 16'hC0DE, 1'b0, rdv, t1, t2);
    chk("R1 long preamble accepted", 32'(we_cnt - base), 32'd1);
    chk("R1 long preamble data", 32'(w_data), 32'h0000C0DE);

    // invalid opcodes
    base = we_cnt;
    frame(32, 2'b00, STRAP, 5'd1, 2'b10, 16'h0, 1'b0, rdv, t1, t2);
    chk("R2 opcode 00 ignored", 32'(we_cnt - base), 32'd0);
    oe_seen = 1'b0;
    frame(32, 2'b11, STRAP, 5'd1, 2'b10, 16'h0, 1'b1, rdv, t1, t2);
    chk("R2 opcode 11 no drive", 32'(oe_seen), 32'd0);
    chk("R2 opcode 11 no write", 32'(we_cnt - base), 32'd0);

    // bad turnaround on write
    frame(32, 2'b01, STRAP, 5'd6, 2'b00, 16'h0, 1'b0, rdv, t1, t2);
    chk("R6 bad turnaround ignored", 32'(we_cnt - base), 32'd0);

    // long stall mid-frame
    stall_ns = 20000;
    frame(32, 2'b10, STRAP, 5'd17, 2'b00, 16'h0, 1'b1, rdv, t1, t2);
    chk("R9 read after stall", 32'(rdv), 32'(model(5'd17)));
    frame(32, 2'b01, STRAP, 5'd30, 2'b10, 16'hBEEF, 1'b0, rdv, t1, t2);
    chk("R9 write after stall", 32'(we_cnt - base), 32'd1);
    chk("R9 write data after stall", 32'(w_data), 32'h0000BEEF);
    stall_ns = 0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule